// File: doc/BRIEF.md
# Triggered Circular Trace Capture Buffer

This block stores a stream of trace words in an on-chip RAM that it uses as a ring. A host sets it up through a small register interface. It loads a post-trigger word count, clears the write pointer and then enables capture. From that point each valid trace word passes through a one-word formatter stage and lands at the write pointer. When a trigger pulse arrives, the block stores exactly the programmed number of further words and then stops accepting data. It then raises an acquisition-complete flag.

A sticky full flag records whether the ring wrapped. With the flag clear, the valid words sit at indexes 0 up to the write pointer minus one. With the flag set, the oldest word sits at the write pointer. The host reads the trace back through a data register. Each read returns the word under the read pointer and then moves that pointer on by one. Read-only registers report an identification value, the RAM depth and the word width.

Top module: `trace_ring_capture`

## Requirements
- R1: After reset the status register (address 3) reads 4'b1000: bit 3 (formatter empty) is set and bits 0 to 2 are clear. The read pointer (5), the write pointer (6), the trigger counter (7) and the control register (8) read 0.
- R2: Address 0 returns ID_VALUE, address 1 returns DEPTH and address 2 returns WIDTH. Writes to addresses 0 to 3 change nothing.
- R3: While control bit 0 is set, each cycle with traceValid high accepts the word into the formatter stage. On the next cycle the word is written at the write pointer, which then advances modulo DEPTH. Status bit 3 reads 0 while a word is pending in the stage.
- R4: Status bit 0 (full) sets when the write pointer wraps from DEPTH-1 to 0. It stays set until it is cleared as described in R9.
- R5: A trigIn pulse while capture is enabled sets status bit 1. A pulse while capture is disabled is ignored. A pulse while bit 1 is already set is ignored.
- R6: Once bit 1 is set, each accepted word decrements the trigger counter (address 7) until it reaches 0. After that no word is accepted, and status bit 2 (acquisition complete) sets together with bit 3. A counter of 0 at trigger time stores no word after the trigger cycle.
- R7: A read of address 4 returns the RAM word at the read pointer and then increments the read pointer modulo DEPTH. A write to address 5 loads the read pointer.
- R8: Writing 0 to the control register stops accepting trace words and keeps the status flags and pointers unchanged.
- R9: A write to the write pointer (address 6), or a control write with bit 0 set, clears full, triggered and acquisition complete.
- R10: Control bit 1 (demultiplexed port mode) is kept only when PORT_BITS is 8. Otherwise it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| traceData | input | WIDTH | Trace word |
| traceValid | input | 1 | Trace word strobe |
| trigIn | input | 1 | Trigger pulse |
| regAddr | input | 4 | Register word address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdEn | input | 1 | Register read strobe (advances read pointer at address 4) |
| regRdData | output | 32 | Register read data for regAddr, combinational |
| isFull | output | 1 | Ring has wrapped |
| isTriggered | output | 1 | Trigger seen |
| acqDone | output | 1 | Acquisition complete |
| fmtEmpty | output | 1 | Formatter stage holds no pending word |

## Verification
The assertions check the following on every cycle:
- the full and triggered flags stay set until a clearing write;
- any write to address 6 clears all three flags;
- acquisition complete never stands without a trigger and always coincides with an empty formatter;
- the write pointer moves only when a word drains;
- each data read steps the read pointer by exactly one.

Only the bench scenarios can show the rest:
- that exactly the programmed number of words lands after the trigger;
- that the contents read back in oldest-first order match what was sent, with and without a wrap;
- that a stop keeps the flags;
- that a zero count ends capture at once;
- that demultiplexed mode is refused for a port width other than 8.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int ADDR_W = 4;

  // register word addresses; the host decodes by these values
  localparam logic [ADDR_W-1:0] REG_IDENT  = 4'd0;
  localparam logic [ADDR_W-1:0] REG_DEPTH  = 4'd1;
  localparam logic [ADDR_W-1:0] REG_WIDTH  = 4'd2;
  localparam logic [ADDR_W-1:0] REG_STATUS = 4'd3;
  localparam logic [ADDR_W-1:0] REG_DATA   = 4'd4;
  localparam logic [ADDR_W-1:0] REG_RDPTR  = 4'd5;
  localparam logic [ADDR_W-1:0] REG_WRPTR  = 4'd6;
  localparam logic [ADDR_W-1:0] REG_TRGCNT = 4'd7;
  localparam logic [ADDR_W-1:0] REG_CTRL   = 4'd8;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;     // load formatter stage with the incoming word
    logic wrPtrLoad;  // host loads write pointer
    logic rdPtrLoad;  // host loads read pointer
    logic rdAdvance;  // data register read, step read pointer
  } trcStrobe_t;
endpackage

// File: rtl/trc_dpath.sv
module trc_dpath
  import trc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 24,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  trcStrobe_t       strb,
  input  logic [PTR_W-1:0] ptrVal,
  input  logic [WIDTH-1:0] traceData,
  output logic             stageValid,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [WIDTH-1:0] rdWord,
  output logic             wrapPulse
);
  logic [WIDTH-1:0] stageData;
  logic [WIDTH-1:0] mem [DEPTH];

  // formatter stage: one word of latency between acceptance and storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      stageData  <= '0;
    end else begin
      stageValid <= strb.accept;
      if (strb.accept) stageData <= traceData;
    end
  end

  always_ff @(posedge clk) begin
    if (stageValid) mem[wrPtr] <= stageData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.wrPtrLoad)   wrPtr <= ptrVal;
      else if (stageValid)  wrPtr <= wrPtr + 1'b1;
      if (strb.rdPtrLoad)   rdPtr <= ptrVal;
      else if (strb.rdAdvance) rdPtr <= rdPtr + 1'b1;
    end
  end

  assign wrapPulse = stageValid && !strb.wrPtrLoad && (wrPtr == PTR_W'(DEPTH - 1));
  assign rdWord    = mem[rdPtr];
endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl
  import trc_pkg::*;
#(
  parameter int          DEPTH     = 16,
  parameter int          WIDTH     = 24,
  parameter int          PORT_BITS = 8,
  parameter logic [31:0] ID_VALUE  = 32'h7ACE_0001,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              traceValid,
  input  logic              trigIn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  input  logic              regRdEn,
  input  logic              stageValid,
  input  logic              wrapPulse,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [WIDTH-1:0]  rdWord,
  output trcStrobe_t        strb,
  output logic [31:0]       regRdData,
  output logic              isFull,
  output logic              isTriggered,
  output logic              acqDone,
  output logic              fmtEmpty
);
  logic             capEn;
  logic             demux;
  logic [CNT_W-1:0] trigCnt;
  logic             wrCtrl, flagClr, cntZero, accept;
  logic             unusedWrBits;

  assign unusedWrBits = ^regWrData;

  assign wrCtrl  = regWrEn && (regAddr == REG_CTRL);
  assign flagClr = (regWrEn && (regAddr == REG_WRPTR)) || (wrCtrl && regWrData[0]);
  assign cntZero = (trigCnt == '0);
  assign accept  = capEn && traceValid && !acqDone && !(isTriggered && cntZero);

  always_comb begin
    strb.accept    = accept;
    strb.wrPtrLoad = regWrEn && (regAddr == REG_WRPTR);
    strb.rdPtrLoad = regWrEn && (regAddr == REG_RDPTR);
    strb.rdAdvance = regRdEn && (regAddr == REG_DATA) && !strb.rdPtrLoad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capEn       <= 1'b0;
      isFull      <= 1'b0;
      isTriggered <= 1'b0;
      acqDone     <= 1'b0;
      trigCnt     <= '0;
    end else begin
      if (wrCtrl) capEn <= regWrData[0];
      if (flagClr) begin
        isFull      <= 1'b0;
        isTriggered <= 1'b0;
        acqDone     <= 1'b0;
      end else begin
        if (wrapPulse) isFull <= 1'b1;
        if (trigIn && capEn) isTriggered <= 1'b1;
        if (capEn && isTriggered && cntZero) acqDone <= 1'b1;
      end
      if (regWrEn && (regAddr == REG_TRGCNT)) trigCnt <= regWrData[CNT_W-1:0];
      else if (accept && isTriggered && !cntZero) trigCnt <= trigCnt - 1'b1;
    end
  end

  // demultiplexed port mode exists only for an 8-bit trace port
  generate
    if (PORT_BITS == 8) begin : g_demux
      always_ff @(posedge clk) begin
        if (!rstN) demux <= 1'b0;
        else if (wrCtrl) demux <= regWrData[1];
      end
    end else begin : g_noDemux
      assign demux = 1'b0;
    end
  endgenerate

  assign fmtEmpty = !stageValid;

  always_comb begin
    case (regAddr)
      REG_IDENT:  regRdData = ID_VALUE;
      REG_DEPTH:  regRdData = 32'(DEPTH);
      REG_WIDTH:  regRdData = 32'(WIDTH);
      REG_STATUS: regRdData = {28'd0, fmtEmpty, acqDone, isTriggered, isFull};
      REG_DATA:   regRdData = 32'(rdWord);
      REG_RDPTR:  regRdData = 32'(rdPtr);
      REG_WRPTR:  regRdData = 32'(wrPtr);
      REG_TRGCNT: regRdData = 32'(trigCnt);
      REG_CTRL:   regRdData = {30'd0, demux, capEn};
      default:    regRdData = 32'd0;
    endcase
  end
endmodule

// File: rtl/trace_ring_capture.sv
module trace_ring_capture
  import trc_pkg::*;
#(
  parameter int          DEPTH     = 16,
  parameter int          WIDTH     = 24,
  parameter int          PORT_BITS = 8,
  parameter logic [31:0] ID_VALUE  = 32'h7ACE_0001,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WIDTH-1:0]  traceData,
  input  logic              traceValid,
  input  logic              trigIn,
  input  logic [3:0]        regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  input  logic              regRdEn,
  output logic [31:0]       regRdData,
  output logic              isFull,
  output logic              isTriggered,
  output logic              acqDone,
  output logic              fmtEmpty
);
  trcStrobe_t       strb;
  logic             stageValid;
  logic             wrapPulse;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [WIDTH-1:0] rdWord;

  trc_ctrl #(
    .DEPTH(DEPTH), .WIDTH(WIDTH), .PORT_BITS(PORT_BITS), .ID_VALUE(ID_VALUE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .traceValid(traceValid), .trigIn(trigIn),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn),
    .stageValid(stageValid), .wrapPulse(wrapPulse), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .rdWord(rdWord), .strb(strb), .regRdData(regRdData), .isFull(isFull),
    .isTriggered(isTriggered), .acqDone(acqDone), .fmtEmpty(fmtEmpty)
  );

  trc_dpath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .ptrVal(regWrData[PTR_W-1:0]),
    .traceData(traceData), .stageValid(stageValid), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .rdWord(rdWord), .wrapPulse(wrapPulse)
  );
endmodule

// File: rtl/trc_checker.sv
module trc_checker #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic [3:0]       regAddr,
  input logic             regWrEn,
  input logic [31:0]      regWrData,
  input logic             regRdEn,
  input logic             isFull,
  input logic             isTriggered,
  input logic             acqDone,
  input logic             fmtEmpty,
  input logic             stageValid,
  input logic [PTR_W-1:0] wrPtr,
  input logic [PTR_W-1:0] rdPtr
);
  logic hostClr, wrPtrWr, rdPtrWr;
  assign wrPtrWr = regWrEn && (regAddr == 4'd6);
  assign rdPtrWr = regWrEn && (regAddr == 4'd5);
  assign hostClr = wrPtrWr || (regWrEn && (regAddr == 4'd8) && regWrData[0]);

  a_r4_full_sticky: assert property (@(posedge clk) disable iff (!rstN)
    isFull && !hostClr |=> isFull);

  a_r5_trig_sticky: assert property (@(posedge clk) disable iff (!rstN)
    isTriggered && !hostClr |=> isTriggered);

  a_r6_done_after_trig: assert property (@(posedge clk) disable iff (!rstN)
    acqDone |-> isTriggered);

  a_r6_done_drained: assert property (@(posedge clk) disable iff (!rstN)
    acqDone |-> fmtEmpty);

  a_r3_wrptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stageValid && !wrPtrWr |=> $stable(wrPtr));

  a_r7_rd_advance: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn && (regAddr == 4'd4) && !rdPtrWr |=> rdPtr == PTR_W'($past(rdPtr) + 1'b1));

  a_r9_wrptr_clears: assert property (@(posedge clk) disable iff (!rstN)
    wrPtrWr |=> !isFull && !isTriggered && !acqDone);
endmodule

bind trace_ring_capture trc_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
  .regRdEn(regRdEn), .isFull(isFull), .isTriggered(isTriggered), .acqDone(acqDone),
  .fmtEmpty(fmtEmpty), .stageValid(stageValid), .wrPtr(wrPtr), .rdPtr(rdPtr)
);

// File: tb/tb_trace_ring_capture.sv
module tb_trace_ring_capture;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int WIDTH = 24;
  localparam logic [31:0] IDV = 32'h7ACE_0001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [WIDTH-1:0] traceData = '0;
  logic traceValid = 1'b0, trigIn = 1'b0;
  logic [3:0] regAddr = '0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData, regRdData2;
  logic isFull, isTriggered, acqDone, fmtEmpty;
  logic f2, t2, a2, e2;

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_ring_capture #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PORT_BITS(8), .ID_VALUE(IDV)) dut (
    .clk(clk), .rstN(rstN), .traceData(traceData), .traceValid(traceValid), .trigIn(trigIn),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn),
    .regRdData(regRdData), .isFull(isFull), .isTriggered(isTriggered), .acqDone(acqDone),
    .fmtEmpty(fmtEmpty));

  // second copy with a 4-bit port, used only for the demux-mode check
  trace_ring_capture #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PORT_BITS(4), .ID_VALUE(IDV)) dut4 (
    .clk(clk), .rstN(rstN), .traceData(traceData), .traceValid(traceValid), .trigIn(trigIn),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn),
    .regRdData(regRdData2), .isFull(f2), .isTriggered(t2), .acqDone(a2), .fmtEmpty(e2));

  // reference state
  bit mEn, mDemux, mTrig, mAcq, mFull, mStageV;
  int mCnt, mWr, mRd;
  logic [WIDTH-1:0] mStageD;
  logic [WIDTH-1:0] mRam [DEPTH];
  logic [31:0] lastRd2;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] expRead(logic [3:0] a);
    case (a)
      4'd0: return IDV;
      4'd1: return DEPTH;
      4'd2: return WIDTH;
      4'd3: return {28'd0, !mStageV, mAcq, mTrig, mFull};
      4'd4: return 32'(mRam[mRd]);
      4'd5: return mRd;
      4'd6: return mWr;
      4'd7: return mCnt;
      4'd8: return {30'd0, mDemux, mEn};
      default: return 0;
    endcase
  endfunction

  task automatic stepModel(bit v, logic [WIDTH-1:0] d, bit t);
    bit acc;
    acc = mEn && v && !mAcq && !(mTrig && mCnt == 0);
    if (mStageV) begin
      mRam[mWr] = mStageD;
      if (mWr == DEPTH-1) mFull = 1;
      mWr = (mWr + 1) % DEPTH;
    end
    if (mEn && mTrig && mCnt == 0) mAcq = 1;
    if (acc && mTrig && mCnt != 0) mCnt--;
    if (t && mEn) mTrig = 1;
    mStageV = acc;
    if (acc) mStageD = d;
  endtask

  task automatic traceCycle(bit v, logic [WIDTH-1:0] d, bit t);
    @(negedge clk);
    traceValid = v; traceData = d; trigIn = t;
    @(posedge clk);
    stepModel(v, d, t);
    #1 traceValid = 0; trigIn = 0;
  endtask

  task automatic hostWrite(logic [3:0] a, logic [31:0] val);
    @(negedge clk);
    regAddr = a; regWrData = val; regWrEn = 1;
    @(posedge clk);
    stepModel(0, '0, 0);
    case (a)
      4'd5: mRd = val % DEPTH;
      4'd6: begin mWr = val % DEPTH; mFull = 0; mTrig = 0; mAcq = 0; end
      4'd7: mCnt = val & 32'h1F;
      4'd8: begin
        mEn = val[0]; mDemux = val[1];
        if (val[0]) begin mFull = 0; mTrig = 0; mAcq = 0; end
      end
      default: ;
    endcase
    #1 regWrEn = 0;
  endtask

  task automatic hostRead(logic [3:0] a, output logic [31:0] val, output logic [31:0] exp);
    @(negedge clk);
    regAddr = a; regRdEn = 1;
    #1 val = regRdData; lastRd2 = regRdData2; exp = expRead(a);
    @(posedge clk);
    stepModel(0, '0, 0);
    if (a == 4'd4) mRd = (mRd + 1) % DEPTH;
    #1 regRdEn = 0;
  endtask

  task automatic readCheck(string req, logic [3:0] a);
    logic [31:0] v, e;
    hostRead(a, v, e);
    check(req, v, e);
  endtask

  task automatic randTrace(int n, int pct, bit trigAt0);
    for (int i = 0; i < n; i++)
      traceCycle(($urandom % 100) < pct, WIDTH'($urandom), trigAt0 && i == 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      bad++; total++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, e;
    void'($urandom(32'd4242));
    mEn = 0; mDemux = 0; mTrig = 0; mAcq = 0; mFull = 0; mStageV = 0;
    mCnt = 0; mWr = 0; mRd = 0; mStageD = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state
    hostRead(4'd3, v, e); check("R1 status", v, 32'h8);
    readCheck("R1 rdptr", 4'd5);
    readCheck("R1 wrptr", 4'd6);
    readCheck("R1 trgcnt", 4'd7);
    readCheck("R1 ctrl", 4'd8);

    // R2 identification and geometry, writes ignored
    hostRead(4'd0, v, e); check("R2 ident", v, IDV);
    hostRead(4'd1, v, e); check("R2 depth", v, DEPTH);
    hostRead(4'd2, v, e); check("R2 width", v, WIDTH);
    for (int a = 0; a < 4; a++) hostWrite(4'(a), $urandom);
    for (int a = 0; a < 4; a++) readCheck("R2 read-only after write", 4'(a));

    // R5 trigger ignored while disabled; R8 nothing stored while disabled
    traceCycle(1, 24'h123456, 1);
    hostRead(4'd3, v, e); check("R5 trigger while disabled", v, 32'h8);
    hostRead(4'd6, v, e); check("R8 no store while disabled", v, 0);

    // Scenario without wrap: count 4, random valid
    hostWrite(4'd7, 4); hostWrite(4'd6, 0); hostWrite(4'd8, 1);
    randTrace(3, 70, 0);
    traceCycle(1, WIDTH'($urandom), 1);
    randTrace(2, 60, 0);
    readCheck("R6 counter mid countdown", 4'd7);
    traceCycle(0, '0, 1);           // second trigger, already triggered
    readCheck("R5 second trigger ignored (counter)", 4'd7);
    readCheck("R5 second trigger ignored (status)", 4'd3);
    randTrace(12, 70, 0);
    readCheck("R6 done status", 4'd3);
    readCheck("R6 counter zero", 4'd7);
    readCheck("R3 write pointer count", 4'd6);
    check("R6 acq complete set", mAcq, 1);
    hostWrite(4'd5, 0);
    for (int i = 0; i < mWr; i++) readCheck("R7 readback no wrap", 4'd4);
    readCheck("R7 read pointer advanced", 4'd5);

    // R8 stop keeps flags
    hostWrite(4'd8, 0);
    randTrace(3, 100, 0);
    readCheck("R8 flags kept after stop", 4'd3);
    readCheck("R8 wrptr kept after stop", 4'd6);

    // Wrap scenario
    hostWrite(4'd7, 6); hostWrite(4'd6, 0); hostWrite(4'd8, 1);
    readCheck("R9 enable clears flags", 4'd3);
    randTrace(40, 100, 0);
    traceCycle(1, WIDTH'($urandom), 1);
    randTrace(10, 100, 0);
    hostRead(4'd3, v, e); check("R4 full after wrap", v, e);
    check("R4 full model", {31'd0, mFull}, 1);
    readCheck("R4 wrptr after wrap", 4'd6);
    hostWrite(4'd5, mWr);
    for (int i = 0; i < DEPTH; i++) readCheck("R7 readback oldest first", 4'd4);

    // R9 write pointer write clears flags
    hostWrite(4'd6, 0);
    hostRead(4'd3, v, e); check("R9 wrptr write clears", v, 32'h8);

    // R6 zero count, R3 formatter pending
    hostWrite(4'd7, 0); hostWrite(4'd8, 1);
    traceCycle(1, 24'hABCDEF, 1);
    hostRead(4'd3, v, e); check("R3 formatter busy", v, 32'h2);
    randTrace(3, 100, 0);
    readCheck("R6 zero count status", 4'd3);
    hostRead(4'd6, v, e); check("R6 zero count wrptr", v, 1);

    // R10 demux mode
    hostWrite(4'd8, 3);
    hostRead(4'd8, v, e); check("R10 demux kept 8-bit", v, 3);
    check("R10 demux refused 4-bit", lastRd2, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule